// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Flag Register

This block is the arithmetic core of a small 8-bit processor. Each cycle it takes the accumulator, a second operand, a carry bit and an operation code. It produces the truncated result at once, with no clock in that path, together with a strobe that tells the register file whether the result should be written back. Alongside, it computes six status bits: sign, zero, half-carry, parity/overflow, subtract and carry. These bits are captured in a flag register on the clock edge, but only when the caller asks for a flag update.

Fetching operands and deciding when an instruction runs belong to the surrounding core. The unit supports eleven operations in four groups:
- add-like and subtract-like operations on the two inputs;
- bitwise operations;
- a compare that only sets flags;
- single-step increment and decrement of the operand, and two's-complement negation of the accumulator.

Top module: `accAlu`

## Requirements
- R1: Opcodes 0 (add), 1 (add with carry), 2 (subtract) and 3 (subtract with borrow) return accumulator ± operand, truncated to 8 bits. Opcodes 1 and 3 also add or subtract `carryIn`. For all four, `resultWrEn` is high.
- R2: For arithmetic opcodes, `flagC` is the carry out of bit 7 (additions) or the borrow out of bit 7 (subtractions). `flagH` is the carry out of bit 3 (additions) or the borrow into bit 4 (subtractions).
- R3: For opcodes 0, 1, 2, 3 and 7, `flagPV` is set exactly when a two's-complement overflow occurs.
- R4: Opcodes 4 (AND), 5 (XOR) and 6 (OR) return the bitwise result. Each clears `flagC` and `flagN` and sets `flagPV` to the even parity of the result. `flagH` is 1 for AND and 0 for OR and XOR.
- R5: `flagN` is 1 after opcodes 2, 3, 7, 9 and 10. It is 0 after opcodes 0, 1, 4, 5, 6 and 8.
- R6: Opcode 7 (compare) sets all flags from accumulator − operand and holds `resultWrEn` low.
- R7: Opcode 8 returns operand+1 and opcode 9 returns operand−1. `flagPV` is set only when the operand was 0x7F (opcode 8) or 0x80 (opcode 9). `flagC` keeps its previous value.
- R8: Opcode 10 returns 0 − accumulator. `flagPV` is set only when the accumulator was 0x80, and `flagC` is set when the accumulator was nonzero.
- R9: `flagS` is bit 7 of the result, and `flagZ` is set when all eight result bits are zero.
- R10: The flags change only on a rising clock edge with `flagWrEn` high, and hold otherwise. A synchronous `rst` clears all six flags to 0.
- R11: Opcodes 11 to 15 hold `resultWrEn` low and leave all flags unchanged, even when `flagWrEn` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| aVal | input | 8 | Accumulator value |
| operand | input | 8 | Second operand |
| carryIn | input | 1 | Incoming carry for add-with-carry and subtract-with-borrow |
| opSel | input | 4 | Operation code |
| flagWrEn | input | 1 | Load the flag register at the next edge |
| result | output | 8 | Combinational result |
| resultWrEn | output | 1 | Result should be written to the destination |
| flagS | output | 1 | Sign flag |
| flagZ | output | 1 | Zero flag |
| flagH | output | 1 | Half-carry flag |
| flagPV | output | 1 | Parity/overflow flag |
| flagN | output | 1 | Subtract flag |
| flagC | output | 1 | Carry flag |

## Verification
The bench uses the default data width of 8. At that width the nibble boundary sits at bit 3, so the directed vectors can reach each named corner exactly: 0x7F and 0x80 for overflow, 0xFF+1 for carry with zero, and 0x00−1 for borrow. A run of random operations with random flag-write enables and carry inputs follows. It exercises flag holding, carry preservation across increment and decrement, and the unused opcodes, all against a behavioural integer model.

// File: rtl/aluPkg.sv
package aluPkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_AND = 4'd4,
    OP_XOR = 4'd5,
    OP_OR  = 4'd6,
    OP_CP  = 4'd7,
    OP_INC = 4'd8,
    OP_DEC = 4'd9,
    OP_NEG = 4'd10
  } aluOp_e;

  typedef enum logic [1:0] {X_ACC, X_OPND, X_ZERO} xSel_e;
  typedef enum logic [1:0] {Y_OPND, Y_ONE, Y_ACC} ySel_e;
  typedef enum logic [1:0] {LOG_AND, LOG_XOR, LOG_OR} logSel_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic     valid;
    logic     writeDest;
    logic     isLogic;
    logSel_e  logSel;
    xSel_e    xSel;
    ySel_e    ySel;
    logic     doSub;
    logic     useCarry;
    logic     keepCarry;
  } aluCtrl_t;

  // Bit positions inside the flag byte
  localparam int FLAG_W   = 8;
  localparam int FB_SIGN  = 7;
  localparam int FB_ZERO  = 6;
  localparam int FB_HALF  = 4;
  localparam int FB_PV    = 2;
  localparam int FB_SUB   = 1;
  localparam int FB_CARRY = 0;

endpackage

// File: rtl/aluControl.sv
module aluControl
  import aluPkg::*;
(
  input  logic [3:0] opSel,
  output aluCtrl_t   ctrl
);

  always_comb begin
    ctrl = '{valid: 1'b0, writeDest: 1'b0, isLogic: 1'b0, logSel: LOG_AND,
             xSel: X_ACC, ySel: Y_OPND, doSub: 1'b0, useCarry: 1'b0,
             keepCarry: 1'b0};
    case (opSel)
      OP_ADD: begin ctrl.valid = 1'b1; ctrl.writeDest = 1'b1; end
      OP_ADC: begin ctrl.valid = 1'b1; ctrl.writeDest = 1'b1; ctrl.useCarry = 1'b1; end
      OP_SUB: begin ctrl.valid = 1'b1; ctrl.writeDest = 1'b1; ctrl.doSub = 1'b1; end
      OP_SBC: begin
        ctrl.valid = 1'b1; ctrl.writeDest = 1'b1;
        ctrl.doSub = 1'b1; ctrl.useCarry = 1'b1;
      end
      OP_AND: begin
        ctrl.valid = 1'b1; ctrl.writeDest = 1'b1;
        ctrl.isLogic = 1'b1; ctrl.logSel = LOG_AND;
      end
      OP_XOR: begin
        ctrl.valid = 1'b1; ctrl.writeDest = 1'b1;
        ctrl.isLogic = 1'b1; ctrl.logSel = LOG_XOR;
      end
      OP_OR: begin
        ctrl.valid = 1'b1; ctrl.writeDest = 1'b1;
        ctrl.isLogic = 1'b1; ctrl.logSel = LOG_OR;
      end
      OP_CP: begin ctrl.valid = 1'b1; ctrl.doSub = 1'b1; end
      OP_INC: begin
        ctrl.valid = 1'b1; ctrl.writeDest = 1'b1;
        ctrl.xSel = X_OPND; ctrl.ySel = Y_ONE; ctrl.keepCarry = 1'b1;
      end
      OP_DEC: begin
        ctrl.valid = 1'b1; ctrl.writeDest = 1'b1; ctrl.doSub = 1'b1;
        ctrl.xSel = X_OPND; ctrl.ySel = Y_ONE; ctrl.keepCarry = 1'b1;
      end
      OP_NEG: begin
        ctrl.valid = 1'b1; ctrl.writeDest = 1'b1; ctrl.doSub = 1'b1;
        ctrl.xSel = X_ZERO; ctrl.ySel = Y_ACC;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] aVal,
  input  logic [DATA_W-1:0] operand,
  input  logic              carryIn,
  input  logic              flagWrEn,
  input  aluCtrl_t          ctrl,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flagsQ
);

  localparam int HALF_W = DATA_W / 2;
  localparam int MSB    = DATA_W - 1;

  logic [DATA_W-1:0] xOp, yOp, yEff, logicRes, arithRes;
  logic [DATA_W:0]   wideSum;
  logic [HALF_W:0]   lowSum;
  logic              cinEff, carryOut, halfOut, overflow;
  logic [FLAG_W-1:0] flagsNext;

  always_comb begin
    case (ctrl.xSel)
      X_OPND:  xOp = operand;
      X_ZERO:  xOp = '0;
      default: xOp = aVal;
    endcase
    case (ctrl.ySel)
      Y_ONE:   yOp = {{(DATA_W-1){1'b0}}, 1'b1};
      Y_ACC:   yOp = aVal;
      default: yOp = operand;
    endcase
  end

  // Subtraction as x + ~y + ~borrow; the carry outputs are inverted back to borrows
  assign yEff     = ctrl.doSub ? ~yOp : yOp;
  assign cinEff   = (ctrl.useCarry & carryIn) ^ ctrl.doSub;
  assign wideSum  = {1'b0, xOp} + {1'b0, yEff} + {{DATA_W{1'b0}}, cinEff};
  assign lowSum   = {1'b0, xOp[HALF_W-1:0]} + {1'b0, yEff[HALF_W-1:0]}
                  + {{HALF_W{1'b0}}, cinEff};
  assign arithRes = wideSum[DATA_W-1:0];
  assign carryOut = wideSum[DATA_W] ^ ctrl.doSub;
  assign halfOut  = lowSum[HALF_W] ^ ctrl.doSub;
  assign overflow = (xOp[MSB] == yEff[MSB]) && (arithRes[MSB] != xOp[MSB]);

  always_comb begin
    case (ctrl.logSel)
      LOG_XOR: logicRes = aVal ^ operand;
      LOG_OR:  logicRes = aVal | operand;
      default: logicRes = aVal & operand;
    endcase
  end

  assign result = ctrl.isLogic ? logicRes : arithRes;

  always_comb begin
    flagsNext           = '0;
    flagsNext[FB_SIGN]  = result[MSB];
    flagsNext[FB_ZERO]  = (result == '0);
    flagsNext[FB_HALF]  = ctrl.isLogic ? (ctrl.logSel == LOG_AND) : halfOut;
    flagsNext[FB_PV]    = ctrl.isLogic ? ~^result : overflow;
    flagsNext[FB_SUB]   = ~ctrl.isLogic & ctrl.doSub;
    flagsNext[FB_CARRY] = ctrl.keepCarry ? flagsQ[FB_CARRY]
                                         : (~ctrl.isLogic & carryOut);
  end

  always_ff @(posedge clk) begin
    if (rst)                          flagsQ <= '0;
    else if (flagWrEn && ctrl.valid)  flagsQ <= flagsNext;
  end

  assert_flags_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !flagWrEn |=> $stable(flagsQ));

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (flagsQ == '0));

  assert_step_keeps_carry_R7: assert property (@(posedge clk) disable iff (rst)
    (flagWrEn && ctrl.keepCarry) |=> (flagsQ[FB_CARRY] == $past(flagsQ[FB_CARRY])));

  assert_logic_clears_nc_R4: assert property (@(posedge clk) disable iff (rst)
    (flagWrEn && ctrl.isLogic) |=> (!flagsQ[FB_SUB] && !flagsQ[FB_CARRY]));

endmodule

// File: rtl/accAlu.sv
module accAlu
  import aluPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] aVal,
  input  logic [DATA_W-1:0] operand,
  input  logic              carryIn,
  input  logic [3:0]        opSel,
  input  logic              flagWrEn,
  output logic [DATA_W-1:0] result,
  output logic              resultWrEn,
  output logic              flagS,
  output logic              flagZ,
  output logic              flagH,
  output logic              flagPV,
  output logic              flagN,
  output logic              flagC
);

  aluCtrl_t          ctrl;
  logic [FLAG_W-1:0] flagsQ;

  aluControl i_control (
    .opSel (opSel),
    .ctrl  (ctrl)
  );

  aluDatapath #(.DATA_W(DATA_W)) i_datapath (
    .clk      (clk),
    .rst      (rst),
    .aVal     (aVal),
    .operand  (operand),
    .carryIn  (carryIn),
    .flagWrEn (flagWrEn),
    .ctrl     (ctrl),
    .result   (result),
    .flagsQ   (flagsQ)
  );

  assign resultWrEn = ctrl.writeDest;
  assign flagS  = flagsQ[FB_SIGN];
  assign flagZ  = flagsQ[FB_ZERO];
  assign flagH  = flagsQ[FB_HALF];
  assign flagPV = flagsQ[FB_PV];
  assign flagN  = flagsQ[FB_SUB];
  assign flagC  = flagsQ[FB_CARRY];

  assert_compare_no_write_R6: assert property (@(posedge clk) disable iff (rst)
    (opSel == OP_CP) |-> !resultWrEn);

  assert_unused_no_write_R11: assert property (@(posedge clk) disable iff (rst)
    (opSel > OP_NEG) |-> !resultWrEn);

  assert_unused_flags_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (opSel > OP_NEG) |=> $stable(flagsQ));

endmodule

// File: tb/test_accAlu.sv
module test_accAlu;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] aVal = '0, operand = '0;
  logic       carryIn = 1'b0;
  logic [3:0] opSel = 4'd0;
  logic       flagWrEn = 1'b0;
  logic [7:0] result;
  logic       resultWrEn, flagS, flagZ, flagH, flagPV, flagN, flagC;

  int checks = 0;
  int fails  = 0;
  logic [7:0] expF = '0;

  always #4 clk = ~clk;

  accAlu #(.DATA_W(8)) i_accAlu (
    .clk(clk), .rst(rst), .aVal(aVal), .operand(operand), .carryIn(carryIn),
    .opSel(opSel), .flagWrEn(flagWrEn), .result(result), .resultWrEn(resultWrEn),
    .flagS(flagS), .flagZ(flagZ), .flagH(flagH), .flagPV(flagPV),
    .flagN(flagN), .flagC(flagC)
  );

  function automatic logic [7:0] flagByte();
    return {flagS, flagZ, 1'b0, flagH, 1'b0, flagPV, flagN, flagC};
  endfunction

  function automatic string tagFor(input int op);
    case (op)
      0, 1, 2, 3: return "R1";
      4, 5, 6:    return "R4";
      7:          return "R6";
      8, 9:       return "R7";
      10:         return "R8";
      default:    return "R11";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp,
                     input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference built from the requirements
  task automatic refModel(input int op, input int a, input int b, input int cin,
                          input logic [7:0] oldF, output int res, output bit wr,
                          output logic [7:0] newF, output bit valid);
    int x, y, c, full, low, s, z, h, pv, n, cy;
    bit isSub, isLog;
    x = a; y = b; c = 0; isSub = 0; isLog = 0; valid = 1; wr = 1;
    h = 0; pv = 0; n = 0; cy = 0; res = 0;
    case (op)
      0: ;
      1: c = cin;
      2: isSub = 1;
      3: begin isSub = 1; c = cin; end
      4: begin isLog = 1; res = a & b; h = 1; end
      5: begin isLog = 1; res = a ^ b; end
      6: begin isLog = 1; res = a | b; end
      7: begin isSub = 1; wr = 0; end
      8: begin x = b; y = 1; end
      9: begin x = b; y = 1; isSub = 1; end
      10: begin x = 0; y = a; isSub = 1; end
      default: begin valid = 0; wr = 0; end
    endcase
    if (!isLog) begin
      if (isSub) begin
        full = x - y - c; low = (x & 15) - (y & 15) - c;
        res = full & 255; cy = (full < 0); h = (low < 0);
        pv = (((x ^ y) & (x ^ res) & 128) != 0); n = 1;
      end else begin
        full = x + y + c; low = (x & 15) + (y & 15) + c;
        res = full & 255; cy = (full > 255); h = (low > 15);
        pv = ((~(x ^ y) & (x ^ res) & 128) != 0);
      end
      if (op == 8 || op == 9) cy = oldF[0];
    end else begin
      pv = ~^res[7:0];
    end
    s = (res >> 7) & 1; z = (res == 0);
    newF = {s[0], z[0], 1'b0, h[0], 1'b0, pv[0], n[0], cy[0]};
  endtask

  task automatic step(input int op, input int a, input int b, input int cin, input bit we);
    int res; bit wr, valid; logic [7:0] nf; string tag;
    tag = tagFor(op);
    @(negedge clk);
    chk(flagByte() == expF, "R10", flagByte(), expF, "flags");
    opSel = op[3:0]; aVal = a[7:0]; operand = b[7:0]; carryIn = cin[0]; flagWrEn = we;
    #1;
    refModel(op, a, b, cin, expF, res, wr, nf, valid);
    chk(resultWrEn == wr, tag, resultWrEn, wr, "resultWrEn");
    if (wr) chk(result == res[7:0], tag, result, res, "result");
    if (we && valid) expF = nf;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(flagByte() == 8'h00, "R10", flagByte(), 0, "reset flags");
    rst = 1'b0;
    // R1/R2/R3/R9 adds
    step(0, 8'h0F, 8'h01, 0, 1);   // H
    step(0, 8'h7F, 8'h01, 0, 1);   // overflow, sign
    step(0, 8'hFF, 8'h01, 0, 1);   // carry, zero
    step(1, 8'h10, 8'h20, 1, 1);   // carry term
    // R1/R2/R3/R5 subtracts
    step(2, 8'h10, 8'h01, 0, 1);
    step(2, 8'h80, 8'h01, 0, 1);
    step(2, 8'h00, 8'h01, 0, 1);   // borrow
    step(3, 8'h05, 8'h05, 1, 1);
    // R4 logic
    step(4, 8'hF0, 8'h3C, 0, 1);
    step(6, 8'h00, 8'h00, 0, 1);
    step(5, 8'hFF, 8'h0F, 0, 1);
    // R6 compare
    step(7, 8'h42, 8'h42, 0, 1);
    step(7, 8'h10, 8'h20, 0, 1);
    // R7 carry preserved across INC/DEC
    step(0, 8'hFF, 8'h01, 0, 1);
    step(8, 8'h00, 8'hFF, 0, 1);
    step(8, 8'h00, 8'h7F, 0, 1);
    step(4, 8'h00, 8'h00, 0, 1);
    step(9, 8'h00, 8'h00, 0, 1);
    step(9, 8'h00, 8'h80, 0, 1);
    // R8 negate
    step(10, 8'h80, 0, 0, 1);
    step(10, 8'h00, 0, 0, 1);
    step(10, 8'h01, 0, 0, 1);
    // R11 unused opcodes, R10 disabled write
    step(12, 8'h00, 8'h00, 1, 1);
    step(15, 8'h80, 8'h80, 1, 1);
    step(2, 8'h00, 8'h01, 0, 0);
    // Random mix
    for (int i = 0; i < 600; i++)
      step($urandom_range(0, 15), $urandom_range(0, 255), $urandom_range(0, 255),
           $urandom_range(0, 1), ($urandom_range(0, 3) != 0));
    // Synchronous reset mid-run, R10
    @(negedge clk);
    chk(flagByte() == expF, "R10", flagByte(), expF, "flags");
    step(0, 8'hFF, 8'h01, 0, 1);
    @(negedge clk);
    flagWrEn = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk(flagByte() == 8'h00, "R10", flagByte(), 0, "sync reset flags");
    rst = 1'b0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule